// File: doc/BRIEF.md
# Mesh Coordinate Discovery and Aligned Launch

Each node of a two-dimensional array of compute nodes carries one copy of this block. The nodes are joined by point-to-point links in four directions. Every node listens on its west and north links and drives its east and south links. At power-up no node knows where it sits. The corner node, strapped as master, takes coordinate (0,0) when it is told to initialise. It then sends a position message east and south. Each receiving node keeps the coordinate it is given and passes on a copy with one axis increased. The coordinate selects the order in which the node walks its share of the grid.

A second phase starts the computation. The master floods a start message over the same links. The node at (x,y) sees this message (x+y) hops after the master does. Each node then holds the message back for the hops still missing to the far corner. As a result, every node in the array raises its one-cycle launch pulse on the same clock cycle. The first iteration needs this: boundary values exchanged between neighbours are only usable if no node runs ahead of the others.

Top module: `mesh_sync_node`

## Requirements
- R1: A link word is 10 bits wide. Bits [9:8] are the kind (00 idle, 01 position, 10 start, 11 never sent), bits [7:4] are x and bits [3:0] are y. Start words carry zero in both coordinate fields.
- R2: A node with is_master high takes coordinate (0,0) on init_req. A node with is_master low ignores init_req and start_req.
- R3: A node without a coordinate takes x and y from the first position word it receives. coord_valid rises on the clock edge that samples the word. If west and north both carry a position word in the same cycle, the west word is taken.
- R4: Once coord_valid is high, it and the coordinate hold until reset. Position words that arrive later change nothing and are not forwarded.
- R5: On taking a coordinate, the node sends a position word (x+1,y) on east_out and (x,y+1) on south_out. Each word is present for one cycle, in the HOP_LAT-th cycle after the sampling edge.
- R6: A node with a coordinate accepts one start per reset, from west, from north, or from start_req on the master. It forwards the start as a start word on both outputs with the same HOP_LAT latency. Later starts are dropped.
- R7: start_pulse is high for exactly one cycle, (XMAX+YMAX-x-y)*HOP_LAT+1 clock edges after the edge that accepts the start.
- R8: In an array whose links carry words straight from neighbour to neighbour, every node ends with its own coordinate, and every node pulses start_pulse on the same cycle.
- R9: While rst is high all input words are ignored. After reset, coord_valid, start_pulse and both link outputs are zero.
- R10: A start that arrives before the node holds a coordinate is dropped. It is neither forwarded nor followed by a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | Strap marking the corner node at (0,0) |
| init_req | input | 1 | Master only: begin coordinate distribution |
| start_req | input | 1 | Master only: begin the launch flood |
| west_in | input | 10 | Word from the west neighbour |
| north_in | input | 10 | Word from the north neighbour |
| east_out | output | 10 | Word to the east neighbour |
| south_out | output | 10 | Word to the south neighbour |
| coord_x | output | 4 | Learned x coordinate |
| coord_y | output | 4 | Learned y coordinate |
| coord_valid | output | 1 | Coordinate is held |
| start_pulse | output | 1 | One-cycle launch of the first iteration |

## Verification
The bound checker watches every cycle for the following:
- coord_valid never falls and the coordinate never changes once it is held.
- start_pulse lasts one cycle and fires at most once per reset.
- No link word of kind 11 is ever sent.
- No position or start word leaves a node that lacks a coordinate.

Some behaviour only the bench scenarios can show. These are the exact arrival cycle of forwarded words and pulses, the west-over-north choice, and the dropping of early or duplicate starts. The same holds for the property that matters most at array level: every node in a 4 by 4 mesh learns the right coordinate, and all sixteen launch pulses land on one cycle.

// File: rtl/mesh_sync_pkg.sv
package mesh_sync_pkg;
  localparam int KIND_W  = 2;
  localparam int COORD_W = 4;
  localparam int MSG_W   = KIND_W + 2 * COORD_W;

  typedef enum logic [KIND_W-1:0] {
    MSG_IDLE  = 2'b00,
    MSG_POS   = 2'b01,
    MSG_START = 2'b10
  } msg_kind_e;

  typedef struct packed {
    msg_kind_e            kind;
    logic [COORD_W-1:0]   x;
    logic [COORD_W-1:0]   y;
  } link_msg_t;
endpackage

// File: rtl/link_delay.sv
module link_delay #(
  parameter int STAGES = 1,
  parameter int W      = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= '0;
        else     pipe[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= '0;
        else     pipe[i] <= pipe[i-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/coord_latch.sv
module coord_latch
  import mesh_sync_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               is_master,
  input  logic               init_req,
  input  link_msg_t          west_msg,
  input  link_msg_t          north_msg,
  output logic               take,
  output logic [COORD_W-1:0] take_x,
  output logic [COORD_W-1:0] take_y,
  output logic [COORD_W-1:0] coord_x,
  output logic [COORD_W-1:0] coord_y,
  output logic               coord_valid
);
  always_comb begin
    take   = 1'b0;
    take_x = '0;
    take_y = '0;
    if (!coord_valid) begin
      if (is_master && init_req) begin
        take = 1'b1;
      end else if (west_msg.kind == MSG_POS) begin
        take   = 1'b1;
        take_x = west_msg.x;
        take_y = west_msg.y;
      end else if (north_msg.kind == MSG_POS) begin
        take   = 1'b1;
        take_x = north_msg.x;
        take_y = north_msg.y;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      coord_valid <= 1'b0;
      coord_x     <= '0;
      coord_y     <= '0;
    end else if (take) begin
      coord_valid <= 1'b1;
      coord_x     <= take_x;
      coord_y     <= take_y;
    end
  end
endmodule

// File: rtl/launch_timer.sv
module launch_timer
  import mesh_sync_pkg::*;
#(
  parameter int XMAX    = 15,
  parameter int YMAX    = 15,
  parameter int HOP_LAT = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig_raw,
  input  logic               coord_valid,
  input  logic [COORD_W-1:0] coord_x,
  input  logic [COORD_W-1:0] coord_y,
  output logic               fire,
  output logic               start_pulse
);
  localparam int SPAN     = XMAX + YMAX;
  localparam int WAIT_MAX = SPAN * HOP_LAT;
  localparam int CNT_W    = ($clog2(WAIT_MAX + 1) > 0) ? $clog2(WAIT_MAX + 1) : 1;

  logic             launched;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] wait_val;

  assign fire = trig_raw && coord_valid && !launched;

  always_comb begin
    wait_val = CNT_W'((SPAN - int'(coord_x) - int'(coord_y)) * HOP_LAT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      launched    <= 1'b0;
      armed       <= 1'b0;
      cnt         <= '0;
      start_pulse <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      if (fire) begin
        launched <= 1'b1;
        armed    <= 1'b1;
        cnt      <= wait_val;
      end else if (armed) begin
        if (cnt == '0) begin
          start_pulse <= 1'b1;
          armed       <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mesh_sync_node.sv
module mesh_sync_node
  import mesh_sync_pkg::*;
#(
  parameter int XMAX    = 15,
  parameter int YMAX    = 15,
  parameter int HOP_LAT = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               is_master,
  input  logic               init_req,
  input  logic               start_req,
  input  logic [MSG_W-1:0]   west_in,
  input  logic [MSG_W-1:0]   north_in,
  output logic [MSG_W-1:0]   east_out,
  output logic [MSG_W-1:0]   south_out,
  output logic [COORD_W-1:0] coord_x,
  output logic [COORD_W-1:0] coord_y,
  output logic               coord_valid,
  output logic               start_pulse
);
  localparam int NDIR = 2;

  link_msg_t          w_msg, n_msg;
  logic               take, fire, trig_raw;
  logic [COORD_W-1:0] take_x, take_y;
  link_msg_t          nxt [NDIR];
  logic [MSG_W-1:0]   outw [NDIR];

  assign w_msg = link_msg_t'(west_in);
  assign n_msg = link_msg_t'(north_in);

  coord_latch u_latch (
    .clk(clk), .rst(rst), .is_master(is_master), .init_req(init_req),
    .west_msg(w_msg), .north_msg(n_msg),
    .take(take), .take_x(take_x), .take_y(take_y),
    .coord_x(coord_x), .coord_y(coord_y), .coord_valid(coord_valid)
  );

  assign trig_raw = (is_master && start_req)
                  || (w_msg.kind == MSG_START)
                  || (n_msg.kind == MSG_START);

  launch_timer #(.XMAX(XMAX), .YMAX(YMAX), .HOP_LAT(HOP_LAT)) u_timer (
    .clk(clk), .rst(rst), .trig_raw(trig_raw), .coord_valid(coord_valid),
    .coord_x(coord_x), .coord_y(coord_y), .fire(fire), .start_pulse(start_pulse)
  );

  // direction 0 = east (x advances), direction 1 = south (y advances)
  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    always_comb begin
      nxt[g] = '{kind: MSG_IDLE, x: '0, y: '0};
      if (take) begin
        nxt[g].kind = MSG_POS;
        nxt[g].x    = (g == 0) ? take_x + 1'b1 : take_x;
        nxt[g].y    = (g == 1) ? take_y + 1'b1 : take_y;
      end else if (fire) begin
        nxt[g].kind = MSG_START;
      end
    end

    link_delay #(.STAGES(HOP_LAT), .W(MSG_W)) u_dly (
      .clk(clk), .rst(rst), .d(nxt[g]), .q(outw[g])
    );
  end

  assign east_out  = outw[0];
  assign south_out = outw[1];
endmodule

module mesh_sync_node_chk #(
  parameter int W  = 10,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          coord_valid,
  input logic [CW-1:0] coord_x,
  input logic [CW-1:0] coord_y,
  input logic          start_pulse,
  input logic [W-1:0]  east_out,
  input logic [W-1:0]  south_out
);
  logic pulsed;
  always_ff @(posedge clk) begin
    if (rst) pulsed <= 1'b0;
    else if (start_pulse) pulsed <= 1'b1;
  end

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst) coord_valid |=> coord_valid); // R4
  AST_COORD_HELD: assert property (@(posedge clk) disable iff (rst) coord_valid |=> ($stable(coord_x) && $stable(coord_y))); // R4
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) start_pulse |=> !start_pulse); // R7
  AST_ONE_LAUNCH: assert property (@(posedge clk) disable iff (rst) start_pulse |-> !pulsed); // R6
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst) (east_out[W-1:W-2] != 2'b11) && (south_out[W-1:W-2] != 2'b11)); // R1
  AST_SEND_NEEDS_COORD: assert property (@(posedge clk) disable iff (rst) (east_out[W-1:W-2] != 2'b00 || south_out[W-1:W-2] != 2'b00) |-> coord_valid); // R10
  AST_PULSE_NEEDS_COORD: assert property (@(posedge clk) disable iff (rst) start_pulse |-> coord_valid); // R6
endmodule

bind mesh_sync_node mesh_sync_node_chk #(.W(mesh_sync_pkg::MSG_W), .CW(mesh_sync_pkg::COORD_W)) u_chk (
  .clk(clk), .rst(rst), .coord_valid(coord_valid), .coord_x(coord_x), .coord_y(coord_y),
  .start_pulse(start_pulse), .east_out(east_out), .south_out(south_out)
);

// File: tb/mesh_sync_node_tb.sv
module mesh_sync_node_tb;
  localparam int NX = 4;
  localparam int NY = 4;
  localparam int L  = 2;
  localparam int XM = NX - 1;
  localparam int YM = NY - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_init = 1'b0, m_start = 1'b0;
  logic [9:0] d_west = '0, d_north = '0;
  int cyc = 0;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // standalone node, non-master
  logic [9:0] u_east, u_south;
  logic [3:0] u_x, u_y;
  logic u_valid, u_pulse;
  mesh_sync_node #(.XMAX(XM), .YMAX(YM), .HOP_LAT(L)) u_dut (
    .clk(clk), .rst(rst), .is_master(1'b0), .init_req(m_init), .start_req(m_start),
    .west_in(d_west), .north_in(d_north), .east_out(u_east), .south_out(u_south),
    .coord_x(u_x), .coord_y(u_y), .coord_valid(u_valid), .start_pulse(u_pulse)
  );

  // 4x4 mesh
  logic [9:0] e_w [NY][NX];
  logic [9:0] s_w [NY][NX];
  logic [3:0] mx [NY][NX];
  logic [3:0] my [NY][NX];
  logic mv [NY][NX];
  logic mp [NY][NX];

  for (genvar gy = 0; gy < NY; gy++) begin : g_row
    for (genvar gx = 0; gx < NX; gx++) begin : g_col
      logic [9:0] win, nin;
      if (gx == 0) begin : g_wedge
        assign win = '0;
      end else begin : g_wlink
        assign win = e_w[gy][gx-1];
      end
      if (gy == 0) begin : g_nedge
        assign nin = '0;
      end else begin : g_nlink
        assign nin = s_w[gy-1][gx];
      end
      mesh_sync_node #(.XMAX(XM), .YMAX(YM), .HOP_LAT(L)) u_node (
        .clk(clk), .rst(rst), .is_master(1'((gx == 0) && (gy == 0))),
        .init_req(m_init), .start_req(m_start),
        .west_in(win), .north_in(nin), .east_out(e_w[gy][gx]), .south_out(s_w[gy][gx]),
        .coord_x(mx[gy][gx]), .coord_y(my[gy][gx]), .coord_valid(mv[gy][gx]),
        .start_pulse(mp[gy][gx])
      );
    end
  end

  // monitors
  int u_pulses = 0, u_pulse_cyc = -1, u_estarts = 0, u_estart_cyc = -1, u_eany = 0;
  int mesh_pulses = 0;
  int pcyc [NY][NX];
  int pcnt [NY][NX];
  initial begin
    for (int y = 0; y < NY; y++) for (int x = 0; x < NX; x++) begin
      pcyc[y][x] = -1; pcnt[y][x] = 0;
    end
  end
  always @(negedge clk) begin
    if (u_pulse) begin u_pulses++; u_pulse_cyc = cyc; end
    if (u_east[9:8] == 2'b10) begin u_estarts++; u_estart_cyc = cyc; end
    if (u_east != 10'd0) u_eany++;
    for (int y = 0; y < NY; y++) for (int x = 0; x < NX; x++) begin
      if (mp[y][x]) begin mesh_pulses++; pcnt[y][x]++; pcyc[y][x] = cyc; end
    end
  end

  function automatic logic [9:0] mk(input logic [1:0] k, input int x, input int y);
    return {k, 4'(x), 4'(y)};
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(4);
    rst = 1'b0;
    step(1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    d_west = mk(2'b01, 5, 5);
    d_north = mk(2'b10, 0, 0);
    step(4);
    d_west = '0; d_north = '0;
    rst = 1'b0;
    step(3);
    check(u_valid == 1'b0, "R9", "coord_valid after reset", u_valid, 0);
    check(u_pulse == 1'b0, "R9", "start_pulse after reset", u_pulse, 0);
    check(u_east == 10'd0, "R9", "east_out after reset", u_east, 0);
    check(u_south == 10'd0, "R9", "south_out after reset", u_south, 0);
  endtask

  task automatic t_early_start();
    int p0 = u_pulses, e0 = u_estarts;
    d_west = mk(2'b10, 0, 0);
    step(1);
    d_west = '0;
    step(20);
    check(u_pulses == p0, "R10", "pulses after early start", u_pulses - p0, 0);
    check(u_estarts == e0, "R10", "start forwarded before coordinate", u_estarts - e0, 0);
  endtask

  task automatic t_pos();
    d_west = mk(2'b01, 2, 1);
    d_north = mk(2'b01, 1, 2);
    step(1);
    d_west = '0; d_north = '0;
    check(u_valid == 1'b1, "R3", "coord_valid after first word", u_valid, 1);
    check(u_x == 4'd2 && u_y == 4'd1, "R3", "west word wins (x*16+y)", u_x * 16 + u_y, 2 * 16 + 1);
    check(u_east == 10'd0, "R5", "east_out before latency", u_east, 0);
    step(1);
    check(u_east == mk(2'b01, 3, 1), "R5", "east position word", u_east, mk(2'b01, 3, 1));
    check(u_south == mk(2'b01, 2, 2), "R5", "south position word", u_south, mk(2'b01, 2, 2));
    step(1);
    check(u_east == 10'd0, "R5", "east word lasts one cycle", u_east, 0);
  endtask

  task automatic t_ignore();
    int a0 = u_eany;
    d_north = mk(2'b01, 7, 7);
    step(1);
    d_north = mk(2'b00, 0, 0);
    d_west = mk(2'b01, 9, 9);
    step(1);
    d_west = '0;
    step(6);
    check(u_x == 4'd2 && u_y == 4'd1, "R4", "coordinate after late position", u_x * 16 + u_y, 33);
    check(u_eany == a0, "R4", "late position forwarded", u_eany - a0, 0);
  endtask

  task automatic t_start();
    int t0 = cyc;
    int p0 = u_pulses;
    d_west = mk(2'b10, 0, 0);
    step(1);
    d_west = '0;
    step(12);
    // accept edge t0+1, wait (6-3)*2=6, visible after edge t0+8
    check(u_pulses == p0 + 1, "R7", "pulse count", u_pulses - p0, 1);
    check(u_pulse_cyc == t0 + 8, "R7", "pulse cycle", u_pulse_cyc - t0, 8);
    check(u_estart_cyc == t0 + 2, "R6", "forwarded start cycle", u_estart_cyc - t0, 2);
  endtask

  task automatic t_second_start();
    int p0 = u_pulses, e0 = u_estarts;
    d_north = mk(2'b10, 0, 0);
    step(1);
    d_north = '0;
    step(20);
    check(u_pulses == p0, "R6", "pulse on second start", u_pulses - p0, 0);
    check(u_estarts == e0, "R6", "second start forwarded", u_estarts - e0, 0);
  endtask

  task automatic t_mesh_early();
    int p0 = mesh_pulses;
    m_start = 1'b1;
    step(1);
    m_start = 1'b0;
    step(30);
    check(mesh_pulses == p0, "R10", "mesh pulses before coordinates", mesh_pulses - p0, 0);
  endtask

  task automatic t_mesh_coords();
    m_init = 1'b1;
    step(1);
    m_init = 1'b0;
    step(40);
    for (int y = 0; y < NY; y++) for (int x = 0; x < NX; x++) begin
      check(mv[y][x] && mx[y][x] == 4'(x) && my[y][x] == 4'(y), (x == 0 && y == 0) ? "R2" : "R8",
            $sformatf("node %0d,%0d coordinate (v*256+x*16+y)", x, y),
            int'(mv[y][x]) * 256 + int'(mx[y][x]) * 16 + int'(my[y][x]), 256 + x * 16 + y);
    end
  endtask

  task automatic t_mesh_launch();
    int t0 = cyc;
    int expc = t0 + 1 + (XM + YM) * L + 1;
    m_start = 1'b1;
    step(1);
    m_start = 1'b0;
    step(40);
    for (int y = 0; y < NY; y++) for (int x = 0; x < NX; x++) begin
      check(pcnt[y][x] == 1, "R7", $sformatf("node %0d,%0d pulse count", x, y), pcnt[y][x], 1);
      check(pcyc[y][x] == expc, "R8", $sformatf("node %0d,%0d pulse cycle", x, y), pcyc[y][x] - t0, expc - t0);
    end
    check(u_valid == 1'b0, "R2", "non-master ignores init_req", u_valid, 0);
  endtask

  initial begin
    t_reset();
    t_early_start();
    t_pos();
    t_ignore();
    t_start();
    t_second_start();
    do_reset();
    t_mesh_early();
    t_mesh_coords();
    t_mesh_launch();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule